// File: doc/BRIEF.md
# Four-Channel DMA Bus-Master Controller

This block moves items between system memory and I/O interfaces on behalf of the processor. Four request lines come from peripherals. Before any transfer, the processor uses a small register-mapped slave port to set up each channel: the memory start address, an item count, a direction, a mode and a mask bit. When an unmasked channel raises its request, the block asks the processor for the bus with a hold request. After the processor grants the bus, the block drives the memory address and the channel acknowledge. It then moves one item as a one-cycle read strobe followed by a one-cycle write strobe. The data travels on the external bus between memory and the interface and never passes through the block.

Each channel runs in one of three modes. Single mode gives the bus back after every item. Block mode keeps the bus while the request stays high, until the count is exhausted. Auto-initialise mode reloads the working address and count from the programmed values when a block ends. A status register reports which channels have reached terminal count and which requests are raised. The terminal-count flags clear when the processor reads the status register.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, `hold`, `addr_en` and `dack` are 0, all four strobes are high, `reg_rdata` is 0, and every channel's mode register reads 4'b1000 (masked).
- R2: Register address bits [3:2] select the channel and bits [1:0] select the register. The registers are:
  - 0: address. A write sets both the programmed and the working address; a read returns the working address.
  - 1: count. A write sets both the programmed and the working count; a read returns the working count.
  - 2: mode. Bit 0 is the direction (1 = I/O to memory), bit 1 is block mode, bit 2 is auto-initialise and bit 3 is mask. A read returns these bits.
  - 3: status, for any channel field. Bits [3:0] are the terminal-count flags and bits [7:4] are the raw request lines.
  - Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R3: Only an idle controller with `hlda` low picks a channel. The lowest-numbered unmasked channel with its request raised wins, and a masked channel's request causes no bus activity.
- R4: `hold` rises one cycle after a channel is picked. Address, `addr_en` and a one-hot `dack` appear only once `hlda` is seen high.
- R5: Each item is one read-strobe cycle followed at once by one write-strobe cycle. Memory-to-I/O uses `mem_rd_n` then `io_wr_n`; I/O-to-memory uses `io_rd_n` then `mem_wr_n`. At most one strobe is low at a time.
- R6: Items are driven at the working address, which steps up by one per item while the working count steps down by one. A programmed count N gives N+1 items, and terminal count is the item moved while the count reads 0 (the count then reads 16'hFFFF).
- R7: In single mode the bus is released after every item and the channel re-arbitrates, so each item is a separate bus tenure.
- R8: In block mode the bus is kept from item to item while the request stays high. It is released after the terminal-count item or after an item during which the request dropped. A later request resumes from the working address and count.
- R9: On release, `addr_en` and `dack` drop first while `hold` stays high for one cycle, then `hold` falls. `hold` does not rise again while `hlda` is still high.
- R10: At terminal count the channel's status flag is set. A channel without auto-initialise sets its own mask and ignores further requests. Reading status clears all flags.
- R11: In auto-initialise mode, terminal count reloads the working address and count from the programmed values, the channel stays unmasked, and the next block repeats the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Slave register address {channel, register} |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the cycle after `reg_rd` |
| dreq | input | 4 | Per-channel transfer requests |
| hlda | input | 1 | Bus grant from the processor |
| hold | output | 1 | Bus request to the processor |
| addr_en | output | 1 | Address and strobes are being driven |
| mem_addr | output | 16 | Memory address of the current item |
| dack | output | 4 | One-hot channel acknowledge |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |

## Verification
The transfer engine is tried in three ways:
- A request held high in single mode, which should yield one tenure per item.
- The same held request in block mode, which should yield a single tenure that ends at terminal count.
- A block-mode request dropped partway, which separates "release on drop" from "release at terminal count" and shows the engine resumes from the stored count.

Four requests raised in the same cycle, one of them masked, show the arbitration order item by item, including that single mode lets the top channel win again. An auto-initialise run whose request ends exactly at terminal count shows the reload and repeated addresses, unlike a plain channel that masks itself. Every item's address and strobe pair is compared against an arithmetic model of address, count and reload.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL,
        ST_DROP
    } bus_st_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_MODE = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    // bit 3 mask, bit 2 reload, bit 1 burst, bit 0 direction (1 = I/O to memory)
    typedef struct packed {
        logic mask;
        logic auto_ld;
        logic blk;
        logic dir_in;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{mask: 1'b1, auto_ld: 1'b0, blk: 1'b0, dir_in: 1'b0};

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_mode,
    input  logic [REG_W-1:0]  wdata,
    input  logic              step,
    input  logic              tc_clr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output chan_cfg_t         cfg,
    output logic              tc_flag,
    output logic              last_item
);

    typedef struct packed {
        logic [ADDR_W-1:0] base_addr;
        logic [ADDR_W-1:0] work_addr;
        logic [CNT_W-1:0]  base_cnt;
        logic [CNT_W-1:0]  work_cnt;
        chan_cfg_t         cfg;
        logic              tc;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_addr) begin
            st_d.base_addr = wdata[ADDR_W-1:0];
            st_d.work_addr = wdata[ADDR_W-1:0];
        end
        if (wr_cnt) begin
            st_d.base_cnt = wdata[CNT_W-1:0];
            st_d.work_cnt = wdata[CNT_W-1:0];
        end
        if (wr_mode) begin
            st_d.cfg = chan_cfg_t'(wdata[3:0]);
        end
        if (tc_clr) begin
            st_d.tc = 1'b0;
        end
        if (step) begin
            st_d.work_addr = st_q.work_addr + ADDR_W'(1);
            st_d.work_cnt  = st_q.work_cnt - CNT_W'(1);
            if (st_q.work_cnt == '0) begin
                st_d.tc = 1'b1;
                if (st_q.cfg.auto_ld) begin
                    st_d.work_addr = st_q.base_addr;
                    st_d.work_cnt  = st_q.base_cnt;
                end else begin
                    st_d.cfg.mask = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{base_addr: '0, work_addr: '0, base_cnt: '0, work_cnt: '0,
                      cfg: CFG_RESET, tc: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr  = st_q.work_addr;
    assign cur_cnt   = st_q.work_cnt;
    assign cfg       = st_q.cfg;
    assign tc_flag   = st_q.tc;
    assign last_item = (st_q.work_cnt == '0);

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] gnt,
    output logic              any,
    output logic [CH_W-1:0]   idx
);

    logic [NUM_CH:0] seen;

    assign seen[0] = 1'b0;

    genvar g;
    for (g = 0; g < NUM_CH; g++) begin : g_prio
        assign gnt[g]    = req[g] & ~seen[g];
        assign seen[g+1] = seen[g] | req[g];
    end

    assign any = seen[NUM_CH];

    always_comb begin
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (gnt[i]) idx = CH_W'(i);
        end
    end

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RA_W  = CH_W + 2,
    localparam int REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] dreq,
    input  logic              hlda,
    output logic              hold,
    output logic              addr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_CH-1:0] dack,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n
);

    typedef struct packed {
        bus_st_e          st;
        logic [CH_W-1:0]  ch;
        logic [REG_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0]        sel;
    logic [CH_W-1:0]   chsel;
    logic [NUM_CH-1:0] wr_a, wr_c, wr_m, step;
    logic [NUM_CH-1:0] mask_v, blk_v, dir_v, tc_v, last_v;
    logic [ADDR_W-1:0] addr_a [NUM_CH];
    logic [CNT_W-1:0]  cnt_a  [NUM_CH];
    chan_cfg_t         cfg_a  [NUM_CH];
    logic [NUM_CH-1:0] arb_gnt;
    logic              arb_any;
    logic [CH_W-1:0]   arb_idx;
    logic              stat_rd;

    assign sel     = reg_addr[1:0];
    assign chsel   = reg_addr[RA_W-1:2];
    assign stat_rd = reg_rd && (sel == SEL_STAT);

    genvar g;
    for (g = 0; g < NUM_CH; g++) begin : g_ch
        assign wr_a[g] = reg_wr && (sel == SEL_ADDR) && (chsel == CH_W'(g));
        assign wr_c[g] = reg_wr && (sel == SEL_CNT)  && (chsel == CH_W'(g));
        assign wr_m[g] = reg_wr && (sel == SEL_MODE) && (chsel == CH_W'(g));
        assign step[g] = (ctl_q.st == ST_WR) && (ctl_q.ch == CH_W'(g));

        dma4_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .REG_W  (REG_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (wr_a[g]),
            .wr_cnt    (wr_c[g]),
            .wr_mode   (wr_m[g]),
            .wdata     (reg_wdata),
            .step      (step[g]),
            .tc_clr    (stat_rd),
            .cur_addr  (addr_a[g]),
            .cur_cnt   (cnt_a[g]),
            .cfg       (cfg_a[g]),
            .tc_flag   (tc_v[g]),
            .last_item (last_v[g])
        );

        assign mask_v[g] = cfg_a[g].mask;
        assign blk_v[g]  = cfg_a[g].blk;
        assign dir_v[g]  = cfg_a[g].dir_in;
    end

    dma4_arb #(
        .NUM_CH (NUM_CH)
    ) u_arb (
        .req (dreq & ~mask_v),
        .gnt (arb_gnt),
        .any (arb_any),
        .idx (arb_idx)
    );

    // next-state and register read path
    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (!hlda && arb_any) begin
                    ctl_d.st = ST_REQ;
                    ctl_d.ch = arb_idx;
                end
            end
            ST_REQ: begin
                if (hlda) ctl_d.st = ST_RD;
            end
            ST_RD: begin
                ctl_d.st = ST_WR;
            end
            ST_WR: begin
                if (last_v[ctl_q.ch] || !blk_v[ctl_q.ch] || !dreq[ctl_q.ch]) begin
                    ctl_d.st = ST_REL;
                end else begin
                    ctl_d.st = ST_RD;
                end
            end
            ST_REL: begin
                ctl_d.st = ST_DROP;
            end
            ST_DROP: begin
                if (!hlda) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (reg_rd) begin
            case (sel)
                SEL_ADDR: ctl_d.rdata = REG_W'(addr_a[chsel]);
                SEL_CNT:  ctl_d.rdata = REG_W'(cnt_a[chsel]);
                SEL_MODE: ctl_d.rdata = {{(REG_W-4){1'b0}}, cfg_a[chsel]};
                default:  ctl_d.rdata = REG_W'({dreq, tc_v});
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, ch: '0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // bus-master outputs decoded from registered state
    logic act, in_rd, in_wr, cur_dir;

    always_comb begin
        in_rd    = (ctl_q.st == ST_RD);
        in_wr    = (ctl_q.st == ST_WR);
        act      = in_rd || in_wr;
        cur_dir  = dir_v[ctl_q.ch];
        hold     = (ctl_q.st == ST_REQ) || act || (ctl_q.st == ST_REL);
        addr_en  = act;
        dack     = act ? (NUM_CH'(1) << ctl_q.ch) : '0;
        mem_addr = act ? addr_a[ctl_q.ch] : '0;
        mem_rd_n = !(in_rd && !cur_dir);
        io_rd_n  = !(in_rd &&  cur_dir);
        io_wr_n  = !(in_wr && !cur_dir);
        mem_wr_n = !(in_wr &&  cur_dir);
    end

    assign reg_rdata = ctl_q.rdata;

endmodule

// File: rtl/dma4_chk.sv
module dma4_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hlda,
    input logic              hold,
    input logic              addr_en,
    input logic [NUM_CH-1:0] dack,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              io_rd_n,
    input logic              io_wr_n
);

    logic any_strobe;
    assign any_strobe = !mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n;

    assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    assert_dack_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |-> (hold && hlda && addr_en));

    assert_strobe_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> (addr_en && dack != '0));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}) >= 3);

    assert_memrd_then_iowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |=> !io_wr_n);

    assert_iord_then_memwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd_n |=> !mem_wr_n);

    assert_release_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_en) |-> hold);

    assert_no_regrab_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!hold) && $past(hlda)) |-> !hold);

endmodule

bind dma4_ctrl dma4_chk #(.NUM_CH(NUM_CH)) u_dma4_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hlda     (hlda),
    .hold     (hold),
    .addr_en  (addr_en),
    .dack     (dack),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n)
);

// File: tb/test_dma4_ctrl.sv
module test_dma4_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  dreq;
    logic        hlda = 1'b0;
    logic        hold, addr_en;
    logic [15:0] mem_addr;
    logic [3:0]  dack;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

    always #4 clk = ~clk;

    dma4_ctrl i_dma4_ctrl (
        .clk (clk), .rst_n (rst_n),
        .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .dreq (dreq), .hlda (hlda), .hold (hold), .addr_en (addr_en),
        .mem_addr (mem_addr), .dack (dack),
        .mem_rd_n (mem_rd_n), .mem_wr_n (mem_wr_n),
        .io_rd_n (io_rd_n), .io_wr_n (io_wr_n)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // processor grant model: two-cycle delay in both directions
    logic [1:0] grant_pipe = '0;
    always @(negedge clk) begin
        grant_pipe <= {grant_pipe[0], hold};
        hlda       <= grant_pipe[1];
    end

    // peripheral and bus model
    bit          req_on   [4];
    int          item_cnt [4];
    int          item_lim [4];
    int          tenure   [4];
    logic [15:0] exp_addr [4];
    int          exp_left [4];
    bit          mdl_dir  [4];
    bit          mdl_auto [4];
    logic [15:0] mdl_base [4];
    logic [15:0] mdl_cnt  [4];
    int          order_q  [32];
    int          order_n = 0;
    bit          rd_seen = 1'b0;
    logic [3:0]  dack_prev = '0;
    logic        hold_prev = 1'b0;
    logic        hlda_prev = 1'b0;

    initial begin
        for (int i = 0; i < 4; i++) begin
            req_on[i] = 0; item_cnt[i] = 0; item_lim[i] = 0; tenure[i] = 0;
            exp_addr[i] = '0; exp_left[i] = 0; mdl_dir[i] = 0; mdl_auto[i] = 0;
            mdl_base[i] = '0; mdl_cnt[i] = '0;
        end
    end

    always_comb begin
        for (int i = 0; i < 4; i++) dreq[i] = req_on[i] && (item_cnt[i] < item_lim[i]);
    end

    always @(negedge clk) begin
        int c;
        if (rst_n) begin
            c = 0;
            for (int i = 0; i < 4; i++) if (dack[i]) c = i;
            for (int i = 0; i < 4; i++) if (dack[i] && !dack_prev[i]) begin
                tenure[i]++;
                chk(hlda && hold, "R4 dack only after grant", {hold, hlda}, 2'b11);
            end
            if (dack_prev != 0 && dack == 0)
                chk(hold, "R9 hold kept one cycle after release", hold, 1);
            if (!hold_prev && hlda_prev)
                chk(!hold, "R9 no new hold while grant high", hold, 0);
            if (!mem_rd_n || !io_rd_n) begin
                chk((mdl_dir[c] ? !io_rd_n : !mem_rd_n) && mem_addr == exp_addr[c],
                    "R5 read strobe and address", {mem_rd_n, io_rd_n, mem_addr},
                    {~mdl_dir[c], mdl_dir[c], exp_addr[c]});
                rd_seen = 1'b1;
            end
            if (!mem_wr_n || !io_wr_n) begin
                chk(rd_seen && (mdl_dir[c] ? !mem_wr_n : !io_wr_n),
                    "R5 write strobe after read", {rd_seen, mem_wr_n, io_wr_n},
                    {1'b1, ~mdl_dir[c], mdl_dir[c]});
                chk(mem_addr == exp_addr[c], "R6 item address", mem_addr, exp_addr[c]);
                rd_seen = 1'b0;
                item_cnt[c]++;
                if (order_n < 32) order_q[order_n] = c;
                order_n++;
                exp_addr[c] = exp_addr[c] + 16'd1;
                exp_left[c]--;
                if (exp_left[c] == 0 && mdl_auto[c]) begin
                    exp_addr[c] = mdl_base[c];
                    exp_left[c] = int'(mdl_cnt[c]) + 1;
                end
            end
            dack_prev = dack;
            hold_prev = hold;
            hlda_prev = hlda;
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic program_ch(input int c, input logic [15:0] a, input logic [15:0] n,
                              input bit dir, input bit blk, input bit auto_ld);
        mdl_dir[c] = dir; mdl_auto[c] = auto_ld; mdl_base[c] = a; mdl_cnt[c] = n;
        exp_addr[c] = a; exp_left[c] = int'(n) + 1;
        reg_write({2'(c), 2'd0}, a);
        reg_write({2'(c), 2'd1}, n);
        reg_write({2'(c), 2'd2}, {12'd0, 1'b0, auto_ld, blk, dir});
    endtask

    task automatic wait_items(input int c, input int n);
        for (int k = 0; k < 5000 && item_cnt[c] < n; k++) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] v;
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({hold, addr_en, dack, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 10'b0000001111,
            "R1 bus outputs idle", {hold, addr_en, dack, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
            10'b0000001111);
        chk(reg_rdata == 16'd0, "R1 read data", reg_rdata, 0);
        for (int c = 0; c < 4; c++) begin
            reg_read({2'(c), 2'd2}, v);
            chk(v == 16'h0008, "R1 channel masked", v, 16'h0008);
        end

        // R2 register map sweep, all channels kept masked
        for (int c = 0; c < 4; c++) begin
            reg_write({2'(c), 2'd0}, 16'h1000 + 16'(c) * 16'h0111);
            reg_write({2'(c), 2'd1}, 16'h0020 + 16'(c));
            reg_write({2'(c), 2'd2}, 16'h0008 | 16'(c));
        end
        for (int c = 0; c < 4; c++) begin
            reg_read({2'(c), 2'd0}, v);
            chk(v == 16'h1000 + 16'(c) * 16'h0111, "R2 address readback", v, 16'h1000 + 16'(c) * 16'h0111);
            reg_read({2'(c), 2'd1}, v);
            chk(v == 16'h0020 + 16'(c), "R2 count readback", v, 16'h0020 + 16'(c));
            reg_read({2'(c), 2'd2}, v);
            chk(v == (16'h0008 | 16'(c)), "R2 mode readback", v, 16'h0008 | 16'(c));
        end

        // R3 masked requests are ignored; R2 status shows raw requests
        for (int c = 0; c < 4; c++) begin item_lim[c] = 1000; req_on[c] = 1; end
        repeat (30) @(negedge clk);
        b = tenure[0] + tenure[1] + tenure[2] + tenure[3];
        chk(!hold && b == 0, "R3 masked channels stay idle", b, 0);
        reg_read(4'b0111, v);
        chk(v == 16'h00F0, "R2 status request field", v, 16'h00F0);
        for (int c = 0; c < 4; c++) req_on[c] = 0;

        // R7 single mode, memory to I/O, count 3 -> 4 items
        program_ch(0, 16'h0100, 16'd3, 1'b0, 1'b0, 1'b0);
        item_lim[0] = item_cnt[0] + 100; req_on[0] = 1;
        wait_items(0, 4);
        chk(item_cnt[0] == 4, "R6 items for count 3", item_cnt[0], 4);
        chk(tenure[0] == 4, "R7 one tenure per item", tenure[0], 4);
        reg_read(4'b0000, v);
        chk(v == 16'h0104, "R6 address after block", v, 16'h0104);
        reg_read(4'b0001, v);
        chk(v == 16'hFFFF, "R6 count wraps past zero", v, 16'hFFFF);
        reg_read(4'b0010, v);
        chk(v == 16'h0008, "R10 channel self-masked", v, 16'h0008);
        reg_read(4'b0011, v);
        chk(v == 16'h0011, "R10 tc flag with request high", v, 16'h0011);
        reg_read(4'b0011, v);
        chk(v == 16'h0010, "R10 status read clears tc", v, 16'h0010);
        repeat (30) @(negedge clk);
        chk(item_cnt[0] == 4 && !hold, "R10 masked channel ignores request", item_cnt[0], 4);
        req_on[0] = 0;

        // R8 block mode, I/O to memory, ends at terminal count with request high
        program_ch(1, 16'h2000, 16'd5, 1'b1, 1'b1, 1'b0);
        item_lim[1] = item_cnt[1] + 100; req_on[1] = 1;
        wait_items(1, 6);
        chk(item_cnt[1] == 6, "R8 block items", item_cnt[1], 6);
        chk(tenure[1] == 1, "R8 single tenure", tenure[1], 1);
        reg_read(4'b0100, v);
        chk(v == 16'h2006, "R6 block end address", v, 16'h2006);
        reg_read(4'b0111, v);
        chk(v == 16'h0022, "R10 tc flag channel 1", v, 16'h0022);
        req_on[1] = 0;

        // R8 block mode interrupted by request drop, then resumed
        program_ch(2, 16'h3000, 16'd9, 1'b0, 1'b1, 1'b0);
        item_lim[2] = item_cnt[2] + 3; req_on[2] = 1;
        wait_items(2, 3);
        chk(item_cnt[2] == 3 && tenure[2] == 1, "R8 release on drop", {item_cnt[2], tenure[2]}, {32'd3, 32'd1});
        reg_read(4'b1001, v);
        chk(v == 16'd6, "R8 count kept after drop", v, 6);
        reg_read(4'b1000, v);
        chk(v == 16'h3003, "R8 address kept after drop", v, 16'h3003);
        reg_read(4'b1010, v);
        chk(v == 16'h0002, "R8 channel still unmasked", v, 16'h0002);
        item_lim[2] = item_cnt[2] + 20;
        wait_items(2, 10);
        chk(item_cnt[2] == 10 && tenure[2] == 2, "R8 resume to terminal count", {item_cnt[2], tenure[2]}, {32'd10, 32'd2});
        req_on[2] = 0;
        reg_read(4'b0011, v);

        // R3 priority: channels 0,1,3 single, 2 masked, all raised together
        program_ch(0, 16'h0500, 16'd1, 1'b0, 1'b0, 1'b0);
        program_ch(1, 16'h0600, 16'd1, 1'b1, 1'b0, 1'b0);
        program_ch(3, 16'h0700, 16'd1, 1'b0, 1'b0, 1'b0);
        reg_write(4'b1010, 16'h0008);
        b = item_cnt[2];
        @(negedge clk);
        order_n = 0;
        for (int c = 0; c < 4; c++) begin item_lim[c] = item_cnt[c] + 100; req_on[c] = 1; end
        wait_items(3, 2);
        chk(order_n == 6, "R3 item total", order_n, 6);
        chk(order_q[0] == 0 && order_q[1] == 0 && order_q[2] == 1 && order_q[3] == 1 &&
            order_q[4] == 3 && order_q[5] == 3, "R3 fixed priority order",
            {order_q[0][3:0], order_q[1][3:0], order_q[2][3:0], order_q[3][3:0], order_q[4][3:0], order_q[5][3:0]},
            24'h001133);
        chk(item_cnt[2] == b, "R3 masked channel not served", item_cnt[2], b);
        for (int c = 0; c < 4; c++) req_on[c] = 0;
        reg_read(4'b0011, v);

        // R11 auto-initialise, block mode, request ends at terminal count
        program_ch(3, 16'h0040, 16'd2, 1'b1, 1'b1, 1'b1);
        b = item_cnt[3];
        item_lim[3] = b + 3; req_on[3] = 1;
        wait_items(3, b + 3);
        reg_read(4'b1100, v);
        chk(v == 16'h0040, "R11 address reloaded", v, 16'h0040);
        reg_read(4'b1101, v);
        chk(v == 16'd2, "R11 count reloaded", v, 2);
        reg_read(4'b1110, v);
        chk(v == 16'h0007, "R11 stays unmasked", v, 16'h0007);
        reg_read(4'b1111, v);
        chk(v == 16'h0008, "R10 tc flag channel 3", v, 16'h0008);
        item_lim[3] = item_cnt[3] + 3;
        wait_items(3, b + 6);
        chk(item_cnt[3] == b + 6, "R11 second block repeats", item_cnt[3], b + 6);
        req_on[3] = 0;

        repeat (10) @(negedge clk);
        summary();
    end

endmodule